// File: doc/BRIEF.md
# Exception Return Load Sequencer

This block carries out a return-from-exception operation inside a processor pipeline. It is handed one instruction word, in either the 32-bit fixed-length form or the two-halfword form, along with the value of the base register it names and the current privilege level. From these it works out where a two-word return frame sits in memory. It then fetches the frame's two words one after the other, using a request/grant address phase and a valid-qualified response phase, with only one read in flight at any time. When both reads finish, it produces a single-cycle return strobe. The strobe carries the word from the lower address as the new program counter and the word from the higher address as the saved status word. It also carries, when asked for, the updated base-register value.

The block also screens each operation. It refuses the operation at the hypervisor level. At the user level it either refuses it or silently skips it, depending on a build-time parameter. It reports undefined encodings, and it raises an unpredictable flag for a base register of 15, for non-zero reserved bits, and for a halfword-pair instruction that sits inside a conditional block without being last in it. A read error ends the operation with an abort pulse.

The sequencer states are IDLE, RD_LO, RD_HI, RETIRE and QUIT. The transitions are:
- IDLE→RD_LO on an accepted start.
- IDLE→QUIT on a refused start.
- RD_LO→RD_HI on a clean first response.
- RD_HI→RETIRE on a clean second response.
- RD_LO/RD_HI→QUIT on an error response.
- RETIRE→IDLE and QUIT→IDLE unconditionally.

Top module: `xret_seq`

## Requirements
- R1: A fixed-length word is accepted only when bits [31:25] = 1111100, bit 22 = 0 and bit 20 = 1. In that form bit 24 is P, bit 23 is U, bit 21 is W and bits [19:16] are the base register number. Any other word gives an `undef_o` pulse and no read.
- R2: In the fixed-length form the direction is "up" when U = 1, and "word-higher" is true when P equals U. All four P/U combinations are supported.
- R3: A halfword-pair word needs bits [31:25] = 1110100, bit 22 = 0 and bit 20 = 1, with bits [24:23] as the mode: 00 is down with word-higher false, and 11 is up with word-higher false. Mode 01 or 10 gives `undef_o` and no read.
- R4: The first read address is the base when going up and base − 8 when going down, plus 4 when word-higher is true. The second read address is the first plus 4.
- R5: On `ret_o`, `new_pc_o` holds the data from the first read and `status_o` holds the data from the second. `ret_o` lasts exactly one cycle.
- R6: When W = 1, `wb_en_o` is high with `ret_o`, and `wb_val_o` is base + 8 when going up or base − 8 when going down. When W = 0, `wb_en_o` stays low.
- R7: At level 2 (`level_i` = 2), an accepted-format word gives `undef_o` and issues no read.
- R8: At level 0, no read is issued. With `EL0_AS_UNDEF` = 1 (the default) `undef_o` pulses; with 0 the block returns to idle with no pulse.
- R9: `unpred_o` pulses with the terminating strobe when the base register number is 15, or when the reserved tail differs from 0x0A00 (fixed form) or from 0xC000 (halfword-pair form). For the halfword-pair form it also pulses when `in_cond_i` = 1 and `last_cond_i` = 0.
- R10: A request stays high, with a stable address, until it is granted. No new request is raised until the response for the granted read has arrived.
- R11: An error response gives `abort_o` and no `ret_o` or `wb_en_o`. An error on the first read prevents the second read.
- R12: `start_i` is sampled only in IDLE. `busy_o` is high from the cycle after an accepted start until the block is back in IDLE, and a start while busy has no effect.
- R13: After reset the block is idle with `busy_o`, `mem_req_o` and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled in IDLE |
| instr_i | input | 32 | Instruction word (halfword-pair form: first halfword in [31:16]) |
| pair_form_i | input | 1 | 1 selects the halfword-pair encoding |
| level_i | input | 2 | Current privilege level (0 user, 1 kernel, 2 hypervisor, 3 monitor) |
| in_cond_i | input | 1 | Instruction sits inside a conditional block |
| last_cond_i | input | 1 | Instruction is last in its conditional block |
| base_i | input | AW | Base register value |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | DW | Read data |
| mem_err_i | input | 1 | Read response is an error |
| busy_o | output | 1 | Operation in progress |
| ret_o | output | 1 | One-cycle return strobe |
| new_pc_o | output | DW | New program counter |
| status_o | output | DW | Saved status word |
| wb_en_o | output | 1 | Base writeback enable, with ret_o |
| wb_val_o | output | AW | Base writeback value |
| undef_o | output | 1 | Undefined-instruction pulse |
| unpred_o | output | 1 | Unpredictable-case pulse |
| abort_o | output | 1 | Read-error abort pulse |

## Verification
The bench walks all four fixed-form P/U combinations and both halfword-pair modes. A design that mixed up the direction or word-higher rule would request the wrong frame address, and would also swap or shift which words arrive as the PC and the status word.

It stalls grants and stretches response latency to catch a request that drops before its grant or that overlaps an outstanding read. It injects errors on the first and on the second read to catch a design that still issues the second read, retires, or writes back after a fault.

It pokes a hypervisor-level start while an operation is running, which a design that resamples inputs outside IDLE would act on. It covers the level and unpredictable screening, including the conditional-block case, both when it fires and when it must not.

// File: rtl/xret_pkg.sv
package xret_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_RETIRE,
        ST_QUIT
    } xr_state_e;

    localparam logic [1:0] LVL_USER = 2'd0;
    localparam logic [1:0] LVL_HYP  = 2'd2;

    localparam logic [6:0]  FIX_TOP  = 7'b1111100;
    localparam logic [15:0] FIX_TAIL = 16'h0A00;
    localparam logic [6:0]  HW_TOP   = 7'b1110100;
    localparam logic [15:0] HW_TAIL  = 16'hC000;
    localparam logic [3:0]  RN_PC    = 4'hF;

    typedef struct packed {
        logic valid;
        logic incr;
        logic wordhi;
        logic wback;
        logic unpred;
    } xr_dec_t;

endpackage

// File: rtl/xret_decode.sv
module xret_decode
    import xret_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        pair_form_i,
    input  logic        in_cond_i,
    input  logic        last_cond_i,
    output xr_dec_t     dec_o
);

    logic       fix_match;
    logic       hw_match;
    logic [3:0] rn;

    assign rn        = instr_i[19:16];
    assign fix_match = (instr_i[31:25] == FIX_TOP) && !instr_i[22] && instr_i[20];
    // halfword-pair mode: only 00 (down) and 11 (up) are legal
    assign hw_match  = (instr_i[31:25] == HW_TOP) && !instr_i[22] && instr_i[20]
                       && (instr_i[24] == instr_i[23]);

    always_comb begin
        dec_o = '0;
        if (!pair_form_i) begin
            if (fix_match) begin
                dec_o.valid  = 1'b1;
                dec_o.incr   = instr_i[23];
                dec_o.wordhi = (instr_i[24] == instr_i[23]);
                dec_o.wback  = instr_i[21];
                dec_o.unpred = (rn == RN_PC) || (instr_i[15:0] != FIX_TAIL);
            end
        end else begin
            if (hw_match) begin
                dec_o.valid  = 1'b1;
                dec_o.incr   = instr_i[24];
                dec_o.wordhi = 1'b0;
                dec_o.wback  = instr_i[21];
                dec_o.unpred = (rn == RN_PC) || (instr_i[15:0] != HW_TAIL)
                               || (in_cond_i && !last_cond_i);
            end
        end
    end

endmodule

// File: rtl/xret_frame.sv
module xret_frame #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0] base_i,
    input  logic          incr_i,
    input  logic          wordhi_i,
    output logic [AW-1:0] lo_addr_o,
    output logic [AW-1:0] hi_addr_o,
    output logic [AW-1:0] wb_val_o
);

    localparam int            WORD_BYTES  = DW / 8;
    localparam int            FRAME_BYTES = 2 * WORD_BYTES;
    localparam logic [AW-1:0] WORD_OFF    = AW'(WORD_BYTES);
    localparam logic [AW-1:0] FRAME_OFF   = AW'(FRAME_BYTES);

    logic [AW-1:0] start_addr;

    always_comb begin
        start_addr = incr_i ? base_i : (base_i - FRAME_OFF);
        lo_addr_o  = wordhi_i ? (start_addr + WORD_OFF) : start_addr;
        hi_addr_o  = lo_addr_o + WORD_OFF;
        wb_val_o   = incr_i ? (base_i + FRAME_OFF) : (base_i - FRAME_OFF);
    end

endmodule

// File: rtl/xret_gate.sv
module xret_gate
    import xret_pkg::*;
#(
    parameter bit EL0_AS_UNDEF = 1'b1
) (
    input  logic [1:0] level_i,
    input  logic       dec_ok_i,
    output logic       go_o,
    output logic       undef_o
);

    logic is_user;
    logic is_hyp;
    logic user_undef;

    assign is_user = (level_i == LVL_USER);
    assign is_hyp  = (level_i == LVL_HYP);

    generate
        if (EL0_AS_UNDEF) begin : g_user_undef
            assign user_undef = is_user;
        end else begin : g_user_skip
            assign user_undef = 1'b0;
        end
    endgenerate

    assign go_o    = dec_ok_i && !is_hyp && !is_user;
    assign undef_o = !dec_ok_i || is_hyp || user_undef;

endmodule

// File: rtl/xret_seq.sv
module xret_seq
    import xret_pkg::*;
#(
    parameter int AW           = 32,
    parameter int DW           = 32,
    parameter bit EL0_AS_UNDEF = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   instr_i,
    input  logic          pair_form_i,
    input  logic [1:0]    level_i,
    input  logic          in_cond_i,
    input  logic          last_cond_i,
    input  logic [AW-1:0] base_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_gnt_i,
    input  logic          mem_rvalid_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_err_i,
    output logic          busy_o,
    output logic          ret_o,
    output logic [DW-1:0] new_pc_o,
    output logic [DW-1:0] status_o,
    output logic          wb_en_o,
    output logic [AW-1:0] wb_val_o,
    output logic          undef_o,
    output logic          unpred_o,
    output logic          abort_o
);

    xr_state_e     state_q, state_d;
    xr_dec_t       dec;
    logic          gate_go, gate_undef;
    logic [AW-1:0] lo_addr, hi_addr, wb_val;

    logic [AW-1:0] lo_q, hi_q, wbv_q;
    logic [DW-1:0] pc_q, st_q;
    logic          wbk_q, unp_q, und_q, abt_q, pend_q;
    logic          reading, resp_ok, resp_bad;

    xret_decode u_decode (
        .instr_i     (instr_i),
        .pair_form_i (pair_form_i),
        .in_cond_i   (in_cond_i),
        .last_cond_i (last_cond_i),
        .dec_o       (dec)
    );

    xret_frame #(.AW(AW), .DW(DW)) u_frame (
        .base_i    (base_i),
        .incr_i    (dec.incr),
        .wordhi_i  (dec.wordhi),
        .lo_addr_o (lo_addr),
        .hi_addr_o (hi_addr),
        .wb_val_o  (wb_val)
    );

    xret_gate #(.EL0_AS_UNDEF(EL0_AS_UNDEF)) u_gate (
        .level_i  (level_i),
        .dec_ok_i (dec.valid),
        .go_o     (gate_go),
        .undef_o  (gate_undef)
    );

    assign reading  = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
    assign resp_ok  = reading && pend_q && mem_rvalid_i && !mem_err_i;
    assign resp_bad = reading && pend_q && mem_rvalid_i && mem_err_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = gate_go ? ST_RD_LO : ST_QUIT;
            ST_RD_LO:  if (resp_bad) state_d = ST_QUIT;
                       else if (resp_ok) state_d = ST_RD_HI;
            ST_RD_HI:  if (resp_bad) state_d = ST_QUIT;
                       else if (resp_ok) state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_IDLE;
            ST_QUIT:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and read tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            wbv_q  <= '0;
            pc_q   <= '0;
            st_q   <= '0;
            wbk_q  <= 1'b0;
            unp_q  <= 1'b0;
            und_q  <= 1'b0;
            abt_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                lo_q   <= lo_addr;
                hi_q   <= hi_addr;
                wbv_q  <= wb_val;
                wbk_q  <= dec.wback;
                unp_q  <= dec.unpred;
                und_q  <= gate_undef;
                abt_q  <= 1'b0;
                pend_q <= 1'b0;
            end
            if (reading) begin
                if (!pend_q && mem_gnt_i)         pend_q <= 1'b1;
                else if (pend_q && mem_rvalid_i)  pend_q <= 1'b0;
            end
            if (resp_bad) abt_q <= 1'b1;
            if (resp_ok && state_q == ST_RD_LO) pc_q <= mem_rdata_i;
            if (resp_ok && state_q == ST_RD_HI) st_q <= mem_rdata_i;
        end
    end

    // outputs
    always_comb begin
        mem_req_o  = reading && !pend_q;
        mem_addr_o = (state_q == ST_RD_HI) ? hi_q : lo_q;
        busy_o     = (state_q != ST_IDLE);
        ret_o      = (state_q == ST_RETIRE);
        wb_en_o    = (state_q == ST_RETIRE) && wbk_q;
        undef_o    = (state_q == ST_QUIT) && und_q;
        abort_o    = (state_q == ST_QUIT) && abt_q;
        unpred_o   = ((state_q == ST_RETIRE) || (state_q == ST_QUIT)) && unp_q;
        new_pc_o   = pc_q;
        status_o   = st_q;
        wb_val_o   = wbv_q;
    end

    // R10: a request is only raised while an operation is in progress
    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    // R10: after a grant, no further request until the response
    p_single_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_gnt_i) |=> !mem_req_o);

    // R10: an ungranted request holds with a stable address
    p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R11: an error response ends in abort and never in a return
    p_err_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_req_o && mem_rvalid_i && mem_err_i) |=> (abort_o && !ret_o && !wb_en_o));

    // R7: hypervisor level is refused with no read
    p_hyp_noload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && level_i == LVL_HYP) |=> (undef_o && !mem_req_o));

    // R5: return strobe is one cycle and leaves the block idle
    p_ret_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_o |=> (!ret_o && !busy_o));

endmodule

// File: tb/xret_seq_test.sv
module xret_seq_test;

    localparam int K_RET = 0;
    localparam int K_UND = 1;
    localparam int K_ABT = 2;

    typedef struct {
        int          kind;
        logic [31:0] pc;
        logic [31:0] st;
        logic [31:0] wbv;
        logic        wben;
        logic        unp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        pair = 1'b0;
    logic [1:0]  level = 2'd1;
    logic        in_cond = 1'b0;
    logic        last_cond = 1'b0;
    logic [31:0] base = '0;
    logic        mem_req, mem_gnt, mem_rvalid, mem_err;
    logic [31:0] mem_addr, mem_rdata;
    logic        busy, ret, wb_en, undef, unpred, abort_s;
    logic [31:0] new_pc, status, wb_val;

    int checks = 0;
    int errors = 0;
    int pend_viol = 0;
    bit out_flag = 0;

    exp_t        expq[$];
    logic [31:0] addrq[$];

    // memory model
    int          stall_cfg = 0;
    int          stall_cnt = 0;
    int          lat_cfg = 1;
    logic [3:0]  rv_cnt = '0;
    logic [31:0] lat_addr = '0;
    logic [31:0] err_addr = 32'hFFFF_FFF0;

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return a ^ 32'hC3C3_5A5A;
    endfunction

    always #4 clk = ~clk;

    assign mem_gnt    = mem_req && (stall_cnt == 0);
    assign mem_rvalid = (rv_cnt == 4'd1);
    assign mem_rdata  = mdata(lat_addr);
    assign mem_err    = mem_rvalid && (lat_addr == err_addr);

    always @(posedge clk) begin
        if (!rst_n) begin
            rv_cnt <= '0;
        end else if (mem_req && mem_gnt) begin
            lat_addr  <= mem_addr;
            rv_cnt    <= 4'(lat_cfg);
            stall_cnt <= stall_cfg;
        end else begin
            if (rv_cnt != 0) rv_cnt <= rv_cnt - 4'd1;
            if (mem_req && stall_cnt != 0) stall_cnt <= stall_cnt - 1;
        end
    end

    xret_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
        .pair_form_i(pair), .level_i(level), .in_cond_i(in_cond),
        .last_cond_i(last_cond), .base_i(base),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
        .busy_o(busy), .ret_o(ret), .new_pc_o(new_pc), .status_o(status),
        .wb_en_o(wb_en), .wb_val_o(wb_val), .undef_o(undef),
        .unpred_o(unpred), .abort_o(abort_s)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fix_word(input logic p, u, w, input logic [3:0] rn);
        return {7'b1111100, p, u, 1'b0, w, 1'b1, rn, 16'h0A00};
    endfunction

    function automatic logic [31:0] pair_word(input logic [1:0] opc, input logic w, input logic [3:0] rn);
        return {7'b1110100, opc, 1'b0, w, 1'b1, rn, 16'hC000};
    endfunction

    // monitor: compares addresses and terminating strobes
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && out_flag) pend_viol++;
            if (mem_rvalid) out_flag = 0;
            if (mem_req && mem_gnt) begin
                if (addrq.size() == 0) chk(0, "R4 unexpected read", mem_addr, 32'h0);
                else begin
                    logic [31:0] a;
                    a = addrq.pop_front();
                    chk(mem_addr == a, "R4 read address", mem_addr, a);
                end
                out_flag = 1;
            end
            if (ret || undef || abort_s) begin
                if (expq.size() == 0) chk(0, "R12 unexpected strobe", {29'd0, ret, undef, abort_s}, 32'h0);
                else begin
                    exp_t e;
                    int   k;
                    e = expq.pop_front();
                    k = ret ? K_RET : (undef ? K_UND : K_ABT);
                    chk(k == e.kind, {e.tag, " outcome kind"}, k, e.kind);
                    chk(unpred == e.unp, {e.tag, " R9 unpredictable flag"}, unpred, e.unp);
                    if (e.kind == K_RET && k == K_RET) begin
                        chk(new_pc == e.pc, {e.tag, " R5 new pc"}, new_pc, e.pc);
                        chk(status == e.st, {e.tag, " R5 status"}, status, e.st);
                        chk(wb_en == e.wben, {e.tag, " R6 writeback enable"}, wb_en, e.wben);
                        if (e.wben) chk(wb_val == e.wbv, {e.tag, " R6 writeback value"}, wb_val, e.wbv);
                    end else begin
                        chk(!wb_en, {e.tag, " R11 no writeback"}, wb_en, 1'b0);
                    end
                end
            end
        end
    end

    task automatic drive(input string tag, input logic [31:0] ins, input logic pr,
                         input logic [1:0] lvl, input logic ic, input logic lc,
                         input logic [31:0] b, input int kind, input logic incr,
                         input logic wh, input logic wb, input logic unp,
                         input logic [31:0] eaddr, input int stl, input int lt,
                         input bit poke);
        logic [31:0] lo, hi;
        exp_t e;
        lo = incr ? b : b - 32'd8;
        if (wh) lo = lo + 32'd4;
        hi = lo + 32'd4;
        err_addr  = eaddr;
        stall_cfg = stl;
        stall_cnt = stl;
        lat_cfg   = lt;
        e.kind = kind; e.pc = mdata(lo); e.st = mdata(hi);
        e.wben = wb; e.wbv = incr ? b + 32'd8 : b - 32'd8;
        e.unp = unp; e.tag = tag;
        if (kind != K_UND) begin
            addrq.push_back(lo);
            if (eaddr != lo) addrq.push_back(hi);
        end
        expq.push_back(e);
        @(negedge clk);
        instr = ins; pair = pr; level = lvl; in_cond = ic; last_cond = lc; base = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R12 busy after start"}, busy, 1'b1);
        if (poke) begin
            @(negedge clk);
            instr = fix_word(1'b0, 1'b1, 1'b1, 4'd2); pair = 1'b0; level = 2'd2;
            base = 32'h0000_7000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(expq.size() == 0, {tag, " R12 result delivered"}, expq.size(), 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(busy == 1'b0, "R13 busy after reset", busy, 1'b0);
        chk(mem_req == 1'b0, "R13 request after reset", mem_req, 1'b0);
        chk(!ret && !undef && !abort_s && !unpred, "R13 strobes after reset",
            {ret, undef, abort_s, unpred}, 4'h0);

        // R2 four fixed-form modes (incr=U, wordhi=(P==U)), R4 addresses, R6 writeback
        drive("R2 dec-after", fix_word(0,0,1,4'd3), 0, 2'd1, 0, 0, 32'h0000_1000,
              K_RET, 0, 1, 1, 0, 32'hFFFF_FFF0, 0, 1, 0);
        drive("R2 dec-before", fix_word(1,0,0,4'd4), 0, 2'd1, 0, 0, 32'h0000_2000,
              K_RET, 0, 0, 0, 0, 32'hFFFF_FFF0, 1, 2, 0);
        drive("R2 inc-after", fix_word(0,1,1,4'd5), 0, 2'd3, 0, 0, 32'h0000_3000,
              K_RET, 1, 0, 1, 0, 32'hFFFF_FFF0, 0, 1, 0);
        drive("R2 inc-before", fix_word(1,1,1,4'd6), 0, 2'd1, 0, 0, 32'h0000_4000,
              K_RET, 1, 1, 1, 0, 32'hFFFF_FFF0, 2, 1, 0);
        // R3 halfword-pair modes; R10 with stalls and long latency
        drive("R3 pair down", pair_word(2'b00,1,4'd7), 1, 2'd1, 0, 0, 32'h0000_5000,
              K_RET, 0, 0, 1, 0, 32'hFFFF_FFF0, 0, 1, 0);
        drive("R3 pair up", pair_word(2'b11,0,4'd8), 1, 2'd1, 0, 0, 32'h0000_6000,
              K_RET, 1, 0, 0, 0, 32'hFFFF_FFF0, 3, 4, 0);
        drive("R3 pair bad mode", pair_word(2'b01,1,4'd8), 1, 2'd1, 0, 0, 32'h0000_6000,
              K_UND, 1, 0, 0, 0, 32'hFFFF_FFF0, 0, 1, 0);
        // R1 unrecognised word (bit 22 set)
        drive("R1 bad word", fix_word(0,1,1,4'd2) | 32'h0040_0000, 0, 2'd1, 0, 0,
              32'h0000_1000, K_UND, 1, 0, 0, 0, 32'hFFFF_FFF0, 0, 1, 0);
        // R7 hypervisor, R8 user
        drive("R7 hyp level", fix_word(0,1,1,4'd2), 0, 2'd2, 0, 0, 32'h0000_1000,
              K_UND, 1, 0, 0, 0, 32'hFFFF_FFF0, 0, 1, 0);
        drive("R8 user level", fix_word(0,1,1,4'd2), 0, 2'd0, 0, 0, 32'h0000_1000,
              K_UND, 1, 0, 0, 0, 32'hFFFF_FFF0, 0, 1, 0);
        // R9 unpredictable cases
        drive("R9 base 15", fix_word(0,1,0,4'hF), 0, 2'd1, 0, 0, 32'h0000_8000,
              K_RET, 1, 0, 0, 1, 32'hFFFF_FFF0, 0, 1, 0);
        drive("R9 fixed tail", fix_word(0,1,0,4'd1) & 32'hFFFF_F7FF, 0, 2'd1, 0, 0,
              32'h0000_8100, K_RET, 1, 0, 0, 1, 32'hFFFF_FFF0, 0, 1, 0);
        drive("R9 cond not last", pair_word(2'b11,0,4'd1), 1, 2'd1, 1, 0, 32'h0000_8200,
              K_RET, 1, 0, 0, 1, 32'hFFFF_FFF0, 0, 1, 0);
        drive("R9 cond last", pair_word(2'b11,0,4'd1), 1, 2'd1, 1, 1, 32'h0000_8300,
              K_RET, 1, 0, 0, 0, 32'hFFFF_FFF0, 0, 1, 0);
        // R11 errors on first and second read
        drive("R11 err first", fix_word(0,1,1,4'd2), 0, 2'd1, 0, 0, 32'h0000_9000,
              K_ABT, 1, 0, 1, 0, 32'h0000_9000, 0, 1, 0);
        drive("R11 err second", fix_word(0,1,1,4'd2), 0, 2'd1, 0, 0, 32'h0000_9100,
              K_ABT, 1, 0, 1, 0, 32'h0000_9104, 1, 2, 0);
        // R12 start while busy is ignored
        drive("R12 poke busy", fix_word(1,1,1,4'd9), 0, 2'd1, 0, 0, 32'h0000_A000,
              K_RET, 1, 1, 1, 0, 32'hFFFF_FFF0, 2, 3, 1);

        chk(addrq.size() == 0, "R4 all reads issued", addrq.size(), 0);
        chk(pend_viol == 0, "R10 no request while outstanding", pend_viol, 0);
        chk(busy == 1'b0, "R12 idle at end", busy, 1'b0);
        finish_run();
    end

endmodule